// File: doc/BRIEF.md
# Serial EEPROM Random Byte Reader

This block fetches one byte from a two-wire serial EEPROM by stepping the clock and data lines directly. A single-cycle start request latches an 8-bit word address. The block then sends the write-control command and the address, issues a fresh start condition with the read-control command, and shifts in one byte. The transaction closes with a wait for the device's no-acknowledge. The byte comes back with a one-cycle done pulse. If any stage fails, the value returned is 0xFF.

Every change of the line pair is followed by a programmable hold time. This keeps the bus slow enough for the attached device no matter how fast the block's own clock runs. The data line is open-drain. The block only ever pulls it low, and a logic one means the line is released. The input is resynchronised through two flops before it is sampled.

The block differs from a textbook two-wire master in three ways. Acknowledges are found by polling, with repeated bit reads. Commands that are not acknowledged are retried from a new start. No stop condition is ever sent.

Top module: `seeprom_rand_reader`

## Requirements
- R1: After reset, `eeClk` is 0, `eeDataLow` is 0 (data released), `rdDone` is 0 and `rdByte` is 0xFF.
- R2: Between two successive changes of the pair {`eeClk`, data level}, at least `HOLD_CYCLES` clock cycles pass.
- R3: A start condition is four line steps, written as (clock, data): (0,1), (1,1), (1,0), (0,1). The data level changes while the clock is high only inside a start.
- R4: A byte is sent MSB first. Each bit takes three steps, clock low, clock high and clock low, with the data level held. The first byte after the first start is `WR_CMD` (0xA0), the next is the word address, and the byte after the second start is `RD_CMD` (0xA1).
- R5: A bit read releases the data line, raises the clock, samples the data input at the end of the hold, keeps the clock high for one more step, then drops it. An acknowledge poll is up to `POLL_LIMIT` (10) bit reads and succeeds on the first 0. A device that acknowledges on the 10th read is accepted, and one that never acknowledges is not.
- R6: A command (write-control or read-control) is tried up to `RETRY_LIMIT` (10) times, each try being start, command byte and acknowledge poll. A command accepted on the 10th try lets the read go on. Ten failures end the operation with 0xFF and no further start.
- R7: The address byte gets exactly one acknowledge poll. If it fails, the result is 0xFF and no further start is issued.
- R8: After the read command is acknowledged, 8 data bits are read MSB first. A no-acknowledge wait of up to 10 reads then succeeds on the first 1, and the byte is returned.
- R9: If all 10 reads of the no-acknowledge wait return 0, the result is 0xFF.
- R10: `startReq` is ignored while a read is in progress. No second transaction follows, and the address is not replaced.
- R11: `rdDone` is high for exactly one cycle per transaction, and `rdByte` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a random read (ignored when busy) |
| wordAddr | input | 8 | EEPROM word address, latched with `startReq` |
| eeDataIn | input | 1 | Level of the shared data line (asynchronous) |
| eeClk | output | 1 | Serial clock line |
| eeDataLow | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| rdByte | output | 8 | Byte read, or 0xFF after a failure |
| rdDone | output | 1 | One-cycle pulse when `rdByte` is updated |

## Verification
The hardest situations to reach are the boundaries of the retry and poll counters. These are a command accepted exactly on its tenth attempt, an acknowledge that arrives on the tenth read of a poll, and their failing counterparts one step further. A device that behaves correctly never produces any of them. The bench therefore contains a behavioural EEPROM model with knobs for how many control bytes of each kind it rejects, on which poll read it acknowledges, whether it acknowledges the address, and whether it holds the data low through the closing no-acknowledge wait. Counting the start conditions the model observes shows, from the ports alone, how many attempts the reader made.

// File: rtl/seeprom_rd_pkg.sv
package seeprom_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_WBYTE, PH_RBIT, PH_FIN
  } phase_e;

  typedef enum logic [2:0] {
    SG_WCMD, SG_ADDR, SG_RCMD, SG_DATA, SG_NACK
  } stage_e;

  typedef enum logic [1:0] {
    TX_WRCMD, TX_ADDR, TX_RDCMD
  } txSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   lineLoad;
    logic   lineClk;
    logic   lineData;
    logic   sampleEn;
    logic   rxShiftEn;
    logic   txLoad;
    txSel_e txSel;
    logic   txShiftEn;
    logic   captureAddr;
    logic   finish;
    logic   finishOk;
  } dpStrobes_t;

endpackage

// File: rtl/seeprom_rd_ctrl.sv
module seeprom_rd_ctrl
  import seeprom_rd_pkg::*;
#(
  parameter int RETRY_LIMIT = 10,
  parameter int POLL_LIMIT  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       holdDone,
  input  logic       txBit,
  input  logic       bitVal,
  input  logic       lineClkQ,
  input  logic       lineDataQ,
  output dpStrobes_t strb
);

  localparam int CNT_W = $clog2(POLL_LIMIT > 8 ? POLL_LIMIT : 8);
  localparam int TRY_W = $clog2(RETRY_LIMIT > 2 ? RETRY_LIMIT : 2);

  phase_e            phase, phaseN;
  stage_e            stage, stageN;
  logic [1:0]        stepIdx, stepN;
  logic [2:0]        bitIdx, bitN;
  logic [CNT_W-1:0]  pollCnt, pollN;
  logic [TRY_W-1:0]  tryCnt, tryN;
  logic              waiting, waitN;
  logic              okFlag, okN;
  logic              stepClk, stepData, lastStep;

  // line levels for the current step of the current phase
  always_comb begin
    stepClk  = 1'b0;
    stepData = 1'b1;
    unique case (phase)
      PH_START: begin
        stepClk  = (stepIdx == 2'd1) || (stepIdx == 2'd2);
        stepData = (stepIdx != 2'd2);
      end
      PH_WBYTE: begin
        stepClk  = (stepIdx == 2'd1);
        stepData = txBit;
      end
      PH_RBIT: begin
        stepClk  = (stepIdx == 2'd1) || (stepIdx == 2'd2);
        stepData = 1'b1;
      end
      default: ;
    endcase
  end

  assign lastStep = (phase == PH_WBYTE) ? (stepIdx == 2'd2) : (stepIdx == 2'd3);

  always_comb begin
    phaseN = phase;  stageN = stage;  stepN = stepIdx;  bitN = bitIdx;
    pollN  = pollCnt; tryN = tryCnt;  waitN = waiting;  okN  = okFlag;
    strb   = '0;
    unique case (phase)
      PH_IDLE: if (startReq) begin
        strb.captureAddr = 1'b1;
        phaseN = PH_START;  stageN = SG_WCMD;
        tryN   = '0;        stepN  = '0;  waitN = 1'b0;
      end
      PH_FIN: begin
        strb.finish   = 1'b1;
        strb.finishOk = okFlag;
        phaseN        = PH_IDLE;
      end
      default: begin
        if (!waiting) begin
          strb.lineLoad = 1'b1;
          strb.lineClk  = stepClk;
          strb.lineData = stepData;
          waitN         = 1'b1;
        end else if (holdDone) begin
          waitN = 1'b0;
          if (phase == PH_RBIT && stepIdx == 2'd1) begin
            strb.sampleEn  = 1'b1;
            strb.rxShiftEn = (stage == SG_DATA);
          end
          if (!lastStep) stepN = stepIdx + 2'd1;
          else begin
            stepN = '0;
            unique case (phase)
              PH_START: begin
                phaseN       = PH_WBYTE;
                bitN         = '0;
                strb.txLoad  = 1'b1;
                strb.txSel   = (stage == SG_RCMD) ? TX_RDCMD : TX_WRCMD;
              end
              PH_WBYTE: begin
                strb.txShiftEn = 1'b1;
                if (bitIdx == 3'd7) begin
                  phaseN = PH_RBIT;
                  pollN  = '0;
                end else bitN = bitIdx + 3'd1;
              end
              default: begin  // PH_RBIT
                if (stage == SG_DATA) begin
                  if (pollCnt == CNT_W'(7)) begin
                    stageN = SG_NACK;  pollN = '0;
                  end else pollN = pollCnt + 1'b1;
                end else if (stage == SG_NACK) begin
                  if (bitVal) begin
                    phaseN = PH_FIN;  okN = 1'b1;
                  end else if (pollCnt == CNT_W'(POLL_LIMIT - 1)) begin
                    phaseN = PH_FIN;  okN = 1'b0;
                  end else pollN = pollCnt + 1'b1;
                end else if (!bitVal) begin  // acknowledge seen
                  if (stage == SG_WCMD) begin
                    stageN = SG_ADDR;  phaseN = PH_WBYTE;  bitN = '0;
                    strb.txLoad = 1'b1;
                    strb.txSel  = TX_ADDR;
                  end else if (stage == SG_ADDR) begin
                    stageN = SG_RCMD;  phaseN = PH_START;  tryN = '0;
                  end else begin
                    stageN = SG_DATA;  pollN = '0;
                  end
                end else if (pollCnt == CNT_W'(POLL_LIMIT - 1)) begin
                  if (stage == SG_ADDR || tryCnt == TRY_W'(RETRY_LIMIT - 1)) begin
                    phaseN = PH_FIN;  okN = 1'b0;
                  end else begin
                    tryN = tryCnt + 1'b1;  phaseN = PH_START;
                  end
                end else pollN = pollCnt + 1'b1;
              end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;  stage  <= SG_WCMD;  stepIdx <= '0;  bitIdx <= '0;
      pollCnt <= '0;       tryCnt <= '0;       waiting <= 1'b0; okFlag <= 1'b0;
    end else begin
      phase   <= phaseN;   stage  <= stageN;   stepIdx <= stepN;  bitIdx <= bitN;
      pollCnt <= pollN;    tryCnt <= tryN;     waiting <= waitN;  okFlag <= okN;
    end
  end

  AST_CLK_HIGH_DATA_ONLY_IN_START: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineLoad && lineClkQ && strb.lineClk && (strb.lineData != lineDataQ))
      |-> (phase == PH_START)); // R3

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !lineClkQ); // R1

endmodule

// File: rtl/seeprom_rd_dp.sv
module seeprom_rd_dp
  import seeprom_rd_pkg::*;
#(
  parameter int         HOLD_CYCLES = 8,
  parameter logic [7:0] WR_CMD      = 8'hA0,
  parameter logic [7:0] RD_CMD      = 8'hA1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t strb,
  input  logic [7:0] wordAddr,
  input  logic       eeDataIn,
  output logic       lineClkQ,
  output logic       lineDataQ,
  output logic       holdDone,
  output logic       txBit,
  output logic       bitVal,
  output logic [7:0] rdByte,
  output logic       rdDone
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] holdCnt;
  logic [7:0]    addrReg, txShift, rxShift;
  logic [1:0]    syncQ;

  assign holdDone = (holdCnt == '0);
  assign txBit    = txShift[7];

  // line registers and hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineClkQ  <= 1'b0;
      lineDataQ <= 1'b1;
      holdCnt   <= '0;
    end else if (strb.lineLoad) begin
      lineClkQ  <= strb.lineClk;
      lineDataQ <= strb.lineData;
      holdCnt   <= HW'(HOLD_CYCLES);
    end else if (!holdDone) begin
      holdCnt   <= holdCnt - 1'b1;
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      txShift <= '0;
    end else begin
      if (strb.captureAddr) addrReg <= wordAddr;
      if (strb.txLoad) begin
        unique case (strb.txSel)
          TX_WRCMD: txShift <= WR_CMD;
          TX_ADDR:  txShift <= addrReg;
          default:  txShift <= RD_CMD;
        endcase
      end else if (strb.txShiftEn) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  // receive path with input resynchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      bitVal  <= 1'b1;
      rxShift <= '0;
      rdByte  <= 8'hFF;
      rdDone  <= 1'b0;
    end else begin
      syncQ  <= {syncQ[0], eeDataIn};
      rdDone <= strb.finish;
      if (strb.sampleEn)  bitVal  <= syncQ[1];
      if (strb.rxShiftEn) rxShift <= {rxShift[6:0], syncQ[1]};
      if (strb.finish)    rdByte  <= strb.finishOk ? rxShift : 8'hFF;
    end
  end

  // gap tracker for the hold assertion
  logic [HW-1:0] sinceChg;
  logic          willChange;
  assign willChange = strb.lineLoad &&
                      ({strb.lineClk, strb.lineData} != {lineClkQ, lineDataQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceChg <= HW'(HOLD_CYCLES);
    else if (willChange)                    sinceChg <= '0;
    else if (sinceChg != HW'(HOLD_CYCLES))  sinceChg <= sinceChg + 1'b1;
  end

  AST_LINE_HOLD_MIN: assert property (@(posedge clk) disable iff (!rstN)
    willChange |-> (sinceChg == HW'(HOLD_CYCLES))); // R2

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone); // R11

  AST_BYTE_STABLE_BETWEEN_DONES: assert property (@(posedge clk) disable iff (!rstN)
    !rdDone |-> $stable(rdByte)); // R11

endmodule

// File: rtl/seeprom_rand_reader.sv
module seeprom_rand_reader
  import seeprom_rd_pkg::*;
#(
  parameter int         HOLD_CYCLES = 8,
  parameter int         RETRY_LIMIT = 10,
  parameter int         POLL_LIMIT  = 10,
  parameter logic [7:0] WR_CMD      = 8'hA0,
  parameter logic [7:0] RD_CMD      = 8'hA1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] wordAddr,
  input  logic       eeDataIn,
  output logic       eeClk,
  output logic       eeDataLow,
  output logic [7:0] rdByte,
  output logic       rdDone
);

  dpStrobes_t strb;
  logic holdDone, txBit, bitVal, lineClkQ, lineDataQ;

  seeprom_rd_ctrl #(
    .RETRY_LIMIT(RETRY_LIMIT),
    .POLL_LIMIT (POLL_LIMIT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .holdDone (holdDone),
    .txBit    (txBit),
    .bitVal   (bitVal),
    .lineClkQ (lineClkQ),
    .lineDataQ(lineDataQ),
    .strb     (strb)
  );

  seeprom_rd_dp #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .WR_CMD     (WR_CMD),
    .RD_CMD     (RD_CMD)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordAddr (wordAddr),
    .eeDataIn (eeDataIn),
    .lineClkQ (lineClkQ),
    .lineDataQ(lineDataQ),
    .holdDone (holdDone),
    .txBit    (txBit),
    .bitVal   (bitVal),
    .rdByte   (rdByte),
    .rdDone   (rdDone)
  );

  assign eeClk     = lineClkQ;
  assign eeDataLow = ~lineDataQ;

endmodule

// File: tb/seeprom_rand_reader_tb.sv
module seeprom_rand_reader_tb_top;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] wordAddr = '0;
  logic       eeDataIn;
  logic       eeClk, eeDataLow;
  logic [7:0] rdByte;
  logic       rdDone;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  seeprom_rand_reader dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordAddr(wordAddr),
    .eeDataIn(eeDataIn), .eeClk(eeClk), .eeDataLow(eeDataLow),
    .rdByte(rdByte), .rdDone(rdDone)
  );

  // ---------------- behavioural EEPROM model ----------------
  logic slaveLow = 1'b0;
  assign eeDataIn = !(eeDataLow || slaveLow);

  int rejWr = 0, rejRd = 0, ackDelay = 0;
  bit addrAck = 1'b1, finLow = 1'b0;
  int mode = 0, rxCnt = 0, byteIdx = 0, ackCnt = 0, txCnt = 0;
  bit ackOk = 1'b0;
  logic [7:0] rxByte = '0, ctrlByte = '0, memAddr = '0;
  logic [7:0] lastWr = '0, lastRd = '0;
  int startCnt = 0, wrAttempts = 0, rdAttempts = 0;

  function automatic logic [7:0] memVal(input logic [7:0] a);
    return (a * 8'd7) ^ 8'h5A;
  endfunction

  always @(posedge eeDataLow) begin
    if (eeClk) begin
      startCnt++;
      mode = 1; rxCnt = 0; byteIdx = 0; slaveLow = 1'b0;
    end
  end

  always @(posedge eeClk) begin
    case (mode)
      1: begin
        rxByte = {rxByte[6:0], !eeDataLow};
        rxCnt++;
        if (rxCnt == 8) begin
          mode = 2; ackCnt = 0;
          if (byteIdx == 0) begin
            ctrlByte = rxByte;
            if (!rxByte[0]) begin lastWr = rxByte; ackOk = (wrAttempts >= rejWr); wrAttempts++; end
            else            begin lastRd = rxByte; ackOk = (rdAttempts >= rejRd); rdAttempts++; end
          end else begin
            memAddr = rxByte; ackOk = addrAck;
          end
        end
      end
      2: begin
        if (ackOk && ackCnt == ackDelay) begin
          slaveLow = 1'b1;
          if (byteIdx == 0 && !ctrlByte[0]) begin mode = 1; rxCnt = 0; byteIdx = 1; end
          else if (byteIdx == 0)            begin mode = 3; txCnt = 0; end
          else                                    mode = 0;
        end else ackCnt++;
      end
      3: begin
        slaveLow = !memVal(memAddr)[7 - txCnt];
        txCnt++;
        if (txCnt == 8) mode = 4;
      end
      4: slaveLow = finLow;
      default: ;
    endcase
  end

  always @(negedge eeClk) slaveLow = 1'b0;

  // ---------------- line monitors ----------------
  int  gap = 0, minGap = 1000000;
  bit  seenChg = 1'b0;
  logic [1:0] prevLines = 2'b01;
  bit  logArm = 1'b0;
  int  logN = 0;
  logic [1:0] logChg [0:15];
  int  doneCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if ({eeClk, !eeDataLow} != prevLines) begin
        if (seenChg && gap < minGap) minGap = gap;
        seenChg = 1'b1;
        gap = 1;
        if (logArm && logN < 16) begin logChg[logN] = {eeClk, !eeDataLow}; logN++; end
      end else gap++;
      prevLines = {eeClk, !eeDataLow};
      if (rdDone) doneCnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setModel(input int wr, input int rd, input int dly, input bit aAck, input bit fLow);
    rejWr = wr; rejRd = rd; ackDelay = dly; addrAck = aAck; finLow = fLow;
    startCnt = 0; wrAttempts = 0; rdAttempts = 0; mode = 0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] got);
    bit seen = 1'b0;
    got = 8'h00;
    @(negedge clk); startReq = 1'b1; wordAddr = a;
    @(negedge clk); startReq = 1'b0;
    for (int i = 0; i < 30000 && !seen; i++) begin
      @(negedge clk);
      if (rdDone) begin seen = 1'b1; got = rdByte; end
    end
    chk(seen, "R11 done seen", int'(seen), 1);
    @(negedge clk);
    chk(!rdDone, "R11 done one cycle", int'(rdDone), 0);
    chk(rdByte == got, "R11 byte held", rdByte, got);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chk(eeClk == 1'b0,     "R1 eeClk", eeClk, 0);
    chk(eeDataLow == 1'b0, "R1 eeDataLow", eeDataLow, 0);
    chk(rdDone == 1'b0,    "R1 rdDone", rdDone, 0);
    chk(rdByte == 8'hFF,   "R1 rdByte", rdByte, 8'hFF);
  endtask

  task automatic testNormal(input logic [7:0] a);
    logic [7:0] got;
    setModel(0, 0, 0, 1'b1, 1'b0);
    doRead(a, got);
    chk(got == memVal(a), "R8 data byte", got, memVal(a));
    chk(startCnt == 2,    "R4 two starts", startCnt, 2);
    chk(lastWr == 8'hA0,  "R4 write cmd", lastWr, 8'hA0);
    chk(lastRd == 8'hA1,  "R4 read cmd", lastRd, 8'hA1);
    chk(memAddr == a,     "R4 address byte", memAddr, a);
  endtask

  task automatic testStartShape();
    logic [7:0] got;
    logic [1:0] expSeq [0:5];
    expSeq[0] = 2'b11; expSeq[1] = 2'b10; expSeq[2] = 2'b01;
    expSeq[3] = 2'b11; expSeq[4] = 2'b01; expSeq[5] = 2'b00;
    setModel(0, 0, 0, 1'b1, 1'b0);
    logN = 0; logArm = 1'b1;
    doRead(8'h21, got);
    logArm = 1'b0;
    for (int k = 0; k < 6; k++)
      chk(logChg[k] == expSeq[k], "R3 start/bit step", logChg[k], expSeq[k]);
    chk(got == memVal(8'h21), "R8 data after shape", got, memVal(8'h21));
  endtask

  task automatic testWrRetry(input int rej, input bit expOk);
    logic [7:0] got, exp;
    setModel(rej, 0, 0, 1'b1, 1'b0);
    doRead(8'h44, got);
    exp = expOk ? memVal(8'h44) : 8'hFF;
    chk(got == exp, "R6 write cmd retry result", got, exp);
    chk(startCnt == (expOk ? rej + 2 : 10), "R6 start count", startCnt, expOk ? rej + 2 : 10);
    if (!expOk) chk(rdAttempts == 0, "R6 no read cmd", rdAttempts, 0);
  endtask

  task automatic testRdRetry(input int rej, input bit expOk);
    logic [7:0] got, exp;
    setModel(0, rej, 0, 1'b1, 1'b0);
    doRead(8'h9C, got);
    exp = expOk ? memVal(8'h9C) : 8'hFF;
    chk(got == exp, "R6 read cmd retry result", got, exp);
    chk(startCnt == (expOk ? rej + 2 : 11), "R6 read start count", startCnt, expOk ? rej + 2 : 11);
  endtask

  task automatic testAddrNack();
    logic [7:0] got;
    setModel(0, 0, 0, 1'b0, 1'b0);
    doRead(8'h37, got);
    chk(got == 8'hFF,  "R7 address nack result", got, 8'hFF);
    chk(startCnt == 1, "R7 single start", startCnt, 1);
  endtask

  task automatic testPollDepth(input int dly, input bit expOk);
    logic [7:0] got, exp;
    setModel(0, 0, dly, 1'b1, 1'b0);
    doRead(8'h6B, got);
    exp = expOk ? memVal(8'h6B) : 8'hFF;
    chk(got == exp, "R5 ack poll depth", got, exp);
    chk(startCnt == (expOk ? 2 : 10), "R5 poll start count", startCnt, expOk ? 2 : 10);
  endtask

  task automatic testFinalNack();
    logic [7:0] got;
    setModel(0, 0, 0, 1'b1, 1'b1);
    doRead(8'h12, got);
    chk(got == 8'hFF, "R9 final nack fail", got, 8'hFF);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] got;
    bit seen = 1'b0;
    int d0;
    setModel(0, 0, 0, 1'b1, 1'b0);
    d0 = doneCnt;
    @(negedge clk); startReq = 1'b1; wordAddr = 8'h58;
    @(negedge clk); startReq = 1'b0;
    repeat (300) @(negedge clk);
    startReq = 1'b1; wordAddr = 8'hC3;
    @(negedge clk); startReq = 1'b0; wordAddr = 8'h00;
    for (int i = 0; i < 30000 && !seen; i++) begin
      @(negedge clk);
      if (rdDone) begin seen = 1'b1; got = rdByte; end
    end
    chk(seen && got == memVal(8'h58), "R10 original address kept", got, memVal(8'h58));
    repeat (3000) @(negedge clk);
    chk(doneCnt - d0 == 1, "R10 single completion", doneCnt - d0, 1);
    chk(startCnt == 2,     "R10 no extra starts", startCnt, 2);
    chk(eeClk == 1'b0,     "R10 bus idle after", eeClk, 0);
  endtask

  // ---------------- main ----------------
  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testStartShape();
    testNormal(8'h00);
    testNormal(8'h13);
    testNormal(8'hFE);
    testWrRetry(3, 1'b1);
    testWrRetry(9, 1'b1);
    testWrRetry(10, 1'b0);
    testRdRetry(9, 1'b1);
    testRdRetry(10, 1'b0);
    testAddrNack();
    testPollDepth(9, 1'b1);
    testPollDepth(10, 1'b0);
    testFinalNack();
    testBusyIgnore();
    chk(minGap >= HOLD, "R2 line hold gap", minGap, HOLD);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule